// File: doc/BRIEF.md
# Four-Stage Escalating Watchdog

A timeout monitor for a processor subsystem. Once enabled, it counts prescaled ticks through four stages, one after another. Each stage has its own hold time and its own action. The action can be nothing, an interrupt, a CPU reset pulse or a system reset pulse. When a stage's hold count runs out, its action fires and the next stage starts from zero. After the last stage the sequence wraps back to the first. Software keeps the system alive by writing the feed register. A feed returns the sequence to the first stage with a zero count.

Software reaches the block through a simple synchronous write/read port. Configuration writes are accepted only while the key register holds the unlock value. The key register itself can always be written, so software locks the block by writing any other value and unlocks it by writing the key back. Configuration writes go into a staged copy. The running copy picks them up only when software sets the commit bit in the control register. Each reset output is a pulse. Its width in clock cycles comes from a parameter table indexed by a 3-bit code.

Top module: `esc_wdog`

## Requirements
- R1: After reset all outputs are low. The key register reads 0x50D83AA1. The stage hold registers read 26000000, 134217727, 1048575 and 1048575. The prescale register reads 1. The control register reads 0x00000900, which means both width codes are 1, all actions are 0 and the enable is 0.
- R2: The registers at word addresses 0 to 6 accept writes only while the key register (address 7) holds 0x50D83AA1. Address 0 is control, 1 is prescale, 2 to 5 are the stage 0 to 3 hold values and 6 is feed. The key register accepts writes at any time. Reads are registered: `rdata_o` shows, one cycle later, the register addressed in the cycle before.
- R3: Staged configuration has no effect until a control write sets bit 30 (commit). One clock after that write, the running configuration takes all staged values, including the ones written by the commit write itself. Control bit layout:
  - bits 2s+1:2s hold the action of stage s;
  - bits 10:8 hold the CPU width code;
  - bits 13:11 hold the system width code;
  - bit 31 is the enable.
- R4: While enabled, stage s ends on the tick that makes its count equal to its hold value (a hold of 0 acts as 1). The next stage then begins at count 0, and stage 3 is followed by stage 0.
- R5: A tick occurs once every max(P,1) clocks, where P is prescale bits 15:0. Writing prescale with bit 31 set clears the divide counter.
- R6: A write to the feed register (address 6) restarts the sequence at stage 0 with a zero count and a cleared divide counter.
- R7: An expiring stage with action 1 sets the raw interrupt bit (address 9, bit 0) two clocks after the expiring tick. `irq_o` is raw AND enable (address 8, bit 0). Address 10 reads the masked value. Writing bit 0 of address 11 clears the raw bit, but a set in the same cycle wins.
- R8: Action 2 starts a `cpu_rst_o` pulse and action 3 starts a `sys_rst_o` pulse. The pulse is CYC[code] clocks wide, where code is the running width code. The default CYC values for codes 0 to 7 are 8, 16, 24, 32, 40, 64, 128 and 256.
- R9: An expiring stage with action 0 changes no output and no interrupt bit.
- R10: While the running enable is 0, the stage, the count and the divide counter stay cleared, and no action fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the register port |
| addr_i | input | 4 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Masked watchdog interrupt |
| cpu_rst_o | output | 1 | CPU reset pulse |
| sys_rst_o | output | 1 | System reset pulse |

## Verification
The hardest situation to reach is one where two mechanisms that both alter the sequence meet in one short window:
- a commit meeting a lock;
- a feed or divide-counter restart landing just before an expiry;
- a width code that has to outlast the following stages.

The stimulus first sets hold values of a few ticks and a prescale of 1 or 3. It then feeds or restarts the divider every two or three clocks, so that an expiry would otherwise fall only a cycle or two later. A behavioural model tracks every clock, and the bench times the first interrupt and the exact pulse lengths against cycle counts worked out from the requirements.

// File: rtl/esc_wdog_pkg.sv
package esc_wdog_pkg;
  localparam int unsigned NSTG   = 4;
  localparam int unsigned HOLD_W = 32;
  localparam int unsigned PRE_W  = 16;
  localparam int unsigned CODE_W = 3;
  localparam int unsigned AW     = 4;
  localparam int unsigned DW     = 32;

  localparam logic [DW-1:0] UNLOCK_KEY = 32'h50D8_3AA1;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_IRQ  = 2'd1,
    ACT_CPU  = 2'd2,
    ACT_SYS  = 2'd3
  } act_e;

  localparam logic [AW-1:0] A_CTRL    = 4'd0;
  localparam logic [AW-1:0] A_PRESC   = 4'd1;
  localparam logic [AW-1:0] A_HOLD    = 4'd2;
  localparam logic [AW-1:0] A_FEED    = 4'd6;
  localparam logic [AW-1:0] A_KEY     = 4'd7;
  localparam logic [AW-1:0] A_IRQ_EN  = 4'd8;
  localparam logic [AW-1:0] A_IRQ_RAW = 4'd9;
  localparam logic [AW-1:0] A_IRQ_ST  = 4'd10;
  localparam logic [AW-1:0] A_IRQ_CLR = 4'd11;

  localparam int unsigned B_EN     = 31;
  localparam int unsigned B_COMMIT = 30;
  localparam int unsigned B_DIVRST = 31;
  localparam int unsigned B_CPU    = 8;
  localparam int unsigned B_SYS    = 11;

  typedef struct packed {
    logic                         en;
    logic [CODE_W-1:0]            sys_code;
    logic [CODE_W-1:0]            cpu_code;
    logic [NSTG-1:0][1:0]         act;
    logic [PRE_W-1:0]             presc;
    logic [NSTG-1:0][HOLD_W-1:0]  hold;
  } cfg_t;
endpackage

// File: rtl/esc_wdog_presc.sv
module esc_wdog_presc #(
  parameter int unsigned PW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          clr_i,
  input  logic [PW-1:0] presc_i,
  output logic          tick_o
);
  logic [PW-1:0] div_q;
  logic [PW:0]   div_nxt;

  assign div_nxt = {1'b0, div_q} + 1'b1;
  // prescale 0 behaves as 1
  assign tick_o  = en_i && (div_nxt >= {1'b0, presc_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         div_q <= '0;
    else if (!en_i || clr_i || tick_o)   div_q <= '0;
    else                                 div_q <= div_q + 1'b1;
  end

  AST_TICK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> div_q == '0); // R5
  AST_RESTART_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> div_q == '0); // R5
endmodule

// File: rtl/esc_wdog_stager.sv
module esc_wdog_stager
  import esc_wdog_pkg::*;
(
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        en_i,
  input  logic                        feed_i,
  input  logic                        tick_i,
  input  logic [NSTG-1:0][HOLD_W-1:0] hold_i,
  input  logic [NSTG-1:0][1:0]        act_i,
  output logic                        fire_o,
  output logic [1:0]                  fire_act_o
);
  localparam int unsigned SW = $clog2(NSTG);

  logic [SW-1:0]     stg_q, stg_nxt;
  logic [HOLD_W-1:0] cnt_q, hold_eff;
  logic [HOLD_W:0]   cnt_nxt;
  logic              expire;

  assign hold_eff = (hold_i[stg_q] == '0) ? HOLD_W'(1) : hold_i[stg_q];
  assign cnt_nxt  = {1'b0, cnt_q} + 1'b1;
  assign expire   = en_i && !feed_i && tick_i && (cnt_nxt >= {1'b0, hold_eff});
  assign stg_nxt  = (stg_q == SW'(NSTG-1)) ? '0 : stg_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= '0;
      cnt_q <= '0;
    end else if (!en_i || feed_i) begin
      stg_q <= '0;
      cnt_q <= '0;
    end else if (tick_i) begin
      if (expire) begin
        stg_q <= stg_nxt;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fire_o     <= 1'b0;
      fire_act_o <= ACT_NONE;
    end else begin
      fire_o     <= expire;
      fire_act_o <= act_i[stg_q];
    end
  end

  AST_STAGE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire && stg_q != SW'(NSTG-1)) |=> stg_q == $past(stg_q) + 1'b1); // R4
  AST_STAGE_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire && stg_q == SW'(NSTG-1)) |=> stg_q == '0); // R4
  AST_FEED_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    feed_i |=> (stg_q == '0 && cnt_q == '0 && !fire_o)); // R6
  AST_IDLE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (stg_q == '0 && cnt_q == '0 && !fire_o)); // R10
endmodule

// File: rtl/esc_wdog_pulse.sv
module esc_wdog_pulse
  import esc_wdog_pkg::*;
#(
  parameter int unsigned                          CW  = 16,
  parameter logic [(1<<CODE_W)-1:0][CW-1:0]       CYC = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              pulse_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (start_i)         cnt_q <= CYC[code_i];
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign pulse_o = (cnt_q != '0);

  AST_PULSE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pulse_o) |-> $past(start_i)); // R8
  AST_PULSE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> cnt_q == $past(CYC[code_i])); // R8
endmodule

// File: rtl/esc_wdog_regs.sv
module esc_wdog_regs
  import esc_wdog_pkg::*;
#(
  parameter logic [NSTG-1:0][HOLD_W-1:0] HOLD_RST = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          fire_i,
  input  logic [1:0]    fire_act_i,
  output cfg_t          cfg_o,
  output logic          feed_o,
  output logic          div_rst_o,
  output logic          irq_o
);
  localparam cfg_t CFG_RST = '{
    en:       1'b0,
    sys_code: CODE_W'(1),
    cpu_code: CODE_W'(1),
    act:      '0,
    presc:    PRE_W'(1),
    hold:     HOLD_RST
  };

  cfg_t          stg_q, act_q;
  logic [DW-1:0] key_q, rd_d;
  logic          commit_q, irq_en_q, irq_raw_q;
  logic          key_ok, wr_ok, irq_set, irq_clr;

  assign key_ok    = (key_q == UNLOCK_KEY);
  assign wr_ok     = wr_en_i && key_ok;
  assign feed_o    = wr_ok && (addr_i == A_FEED);
  assign div_rst_o = wr_ok && (addr_i == A_PRESC) && wdata_i[B_DIVRST];
  assign irq_set   = fire_i && (fire_act_i == ACT_IRQ);
  assign irq_clr   = wr_en_i && (addr_i == A_IRQ_CLR) && wdata_i[0];

  always_comb begin
    rd_d = '0;
    case (addr_i)
      A_CTRL: begin
        rd_d[B_EN]             = stg_q.en;
        rd_d[B_SYS +: CODE_W]  = stg_q.sys_code;
        rd_d[B_CPU +: CODE_W]  = stg_q.cpu_code;
        rd_d[2*NSTG-1:0]       = stg_q.act;
      end
      A_PRESC:   rd_d[PRE_W-1:0] = stg_q.presc;
      A_KEY:     rd_d = key_q;
      A_IRQ_EN:  rd_d[0] = irq_en_q;
      A_IRQ_RAW: rd_d[0] = irq_raw_q;
      A_IRQ_ST:  rd_d[0] = irq_raw_q & irq_en_q;
      default:   rd_d = '0;
    endcase
    for (int i = 0; i < NSTG; i++) begin
      if (addr_i == A_HOLD + AW'(i)) rd_d[HOLD_W-1:0] = stg_q.hold[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q     <= CFG_RST;
      act_q     <= CFG_RST;
      key_q     <= UNLOCK_KEY;
      commit_q  <= 1'b0;
      irq_en_q  <= 1'b0;
      irq_raw_q <= 1'b0;
      rdata_o   <= '0;
    end else begin
      rdata_o  <= rd_d;
      commit_q <= wr_ok && (addr_i == A_CTRL) && wdata_i[B_COMMIT];
      if (commit_q) act_q <= stg_q;
      // key stays writable so software can relock
      if (wr_en_i && addr_i == A_KEY)    key_q    <= wdata_i;
      if (wr_en_i && addr_i == A_IRQ_EN) irq_en_q <= wdata_i[0];
      if (irq_set)      irq_raw_q <= 1'b1;
      else if (irq_clr) irq_raw_q <= 1'b0;
      if (wr_ok) begin
        if (addr_i == A_CTRL) begin
          stg_q.en       <= wdata_i[B_EN];
          stg_q.sys_code <= wdata_i[B_SYS +: CODE_W];
          stg_q.cpu_code <= wdata_i[B_CPU +: CODE_W];
          stg_q.act      <= wdata_i[2*NSTG-1:0];
        end
        if (addr_i == A_PRESC) stg_q.presc <= wdata_i[PRE_W-1:0];
        for (int i = 0; i < NSTG; i++) begin
          if (addr_i == A_HOLD + AW'(i)) stg_q.hold[i] <= wdata_i[HOLD_W-1:0];
        end
      end
    end
  end

  assign cfg_o = act_q;
  assign irq_o = irq_raw_q & irq_en_q;

  AST_LOCKED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !key_ok && addr_i == A_HOLD) |=> $stable(stg_q.hold[0])); // R2
  AST_KEY_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_KEY) |=> key_q == $past(wdata_i)); // R2
  AST_COMMIT_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(act_q) |-> $past(commit_q)); // R3
  AST_IRQ_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_raw_q) |-> $past(irq_set)); // R7
endmodule

// File: rtl/esc_wdog.sv
module esc_wdog
  import esc_wdog_pkg::*;
#(
  parameter logic [NSTG-1:0][HOLD_W-1:0] HOLD_RST =
    {32'd1048575, 32'd1048575, 32'd134217727, 32'd26000000},
  parameter int unsigned PW_W = 16,
  parameter logic [(1<<CODE_W)-1:0][PW_W-1:0] PULSE_CYC =
    {16'd256, 16'd128, 16'd64, 16'd40, 16'd32, 16'd24, 16'd16, 16'd8}
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o,
  output logic          cpu_rst_o,
  output logic          sys_rst_o
);
  cfg_t       cfg;
  logic       feed, div_rst, tick, fire;
  logic [1:0] fire_act;
  logic [1:0] rst_vec;

  esc_wdog_regs #(.HOLD_RST(HOLD_RST)) regs_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .rdata_o    (rdata_o),
    .fire_i     (fire),
    .fire_act_i (fire_act),
    .cfg_o      (cfg),
    .feed_o     (feed),
    .div_rst_o  (div_rst),
    .irq_o      (irq_o)
  );

  esc_wdog_presc #(.PW(PRE_W)) presc_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (cfg.en),
    .clr_i   (div_rst | feed),
    .presc_i (cfg.presc),
    .tick_o  (tick)
  );

  esc_wdog_stager stager_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (cfg.en),
    .feed_i     (feed),
    .tick_i     (tick),
    .hold_i     (cfg.hold),
    .act_i      (cfg.act),
    .fire_o     (fire),
    .fire_act_o (fire_act)
  );

  for (genvar g = 0; g < 2; g++) begin : g_pulse
    localparam logic [1:0] TRIG = (g == 0) ? ACT_CPU : ACT_SYS;
    logic [CODE_W-1:0] code;
    assign code = (g == 0) ? cfg.cpu_code : cfg.sys_code;
    esc_wdog_pulse #(.CW(PW_W), .CYC(PULSE_CYC)) pulse_i (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (fire && fire_act == TRIG),
      .code_i  (code),
      .pulse_o (rst_vec[g])
    );
  end

  assign cpu_rst_o = rst_vec[0];
  assign sys_rst_o = rst_vec[1];

  AST_NONE_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && fire_act == ACT_NONE) |=> ($stable(rst_vec) || !rst_vec[0] || !rst_vec[1])); // R9
endmodule

// File: tb/esc_wdog_tb_top.sv
module esc_wdog_tb_top;
  localparam logic [31:0] MAGIC = 32'h50D8_3AA1;
  localparam int WID [8] = '{8, 16, 24, 32, 40, 64, 128, 256};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wd = '0;
  logic [31:0] rdata;
  logic        irq, cpu, sys;

  always #4 clk = ~clk;

  esc_wdog dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr), .addr_i(addr), .wdata_i(wd),
    .rdata_o(rdata), .irq_o(irq), .cpu_rst_o(cpu), .sys_rst_o(sys)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  int cyc     = 0;

  // behavioural reference state
  logic [31:0] m_key, m_rd;
  int          s_act[4], a_act[4];
  int          s_cpu, s_sys, a_cpu, a_sys;
  bit          s_en, a_en, m_commit, m_ien, m_raw, m_fire;
  longint      s_pre, a_pre, s_hold[4], a_hold[4], m_div, m_cnt;
  int          m_stage, m_fact;
  int          m_pc[2];

  function automatic logic [31:0] rd_val(input logic [3:0] a);
    logic [31:0] v = '0;
    case (a)
      4'd0: begin
        v[31] = s_en; v[13:11] = 3'(s_sys); v[10:8] = 3'(s_cpu);
        for (int i = 0; i < 4; i++) v[2*i +: 2] = 2'(s_act[i]);
      end
      4'd1: v = 32'(s_pre);
      4'd2, 4'd3, 4'd4, 4'd5: v = 32'(s_hold[a-2]);
      4'd7: v = m_key;
      4'd8: v = {31'd0, m_ien};
      4'd9: v = {31'd0, m_raw};
      4'd10: v = {31'd0, m_raw & m_ien};
      default: v = '0;
    endcase
    return v;
  endfunction

  always @(posedge clk) begin : ref_model
    bit kok, feed, drst, tick, fire_n;
    int fact_n;
    longint heff, peff;
    logic [31:0] rd_n;
    if (!rst_n) begin
      m_key = MAGIC; m_rd = '0;
      s_en = 0; a_en = 0; s_cpu = 1; a_cpu = 1; s_sys = 1; a_sys = 1;
      s_pre = 1; a_pre = 1;
      s_hold[0] = 26000000; s_hold[1] = 134217727; s_hold[2] = 1048575; s_hold[3] = 1048575;
      for (int i = 0; i < 4; i++) begin s_act[i] = 0; a_act[i] = 0; a_hold[i] = s_hold[i]; end
      m_commit = 0; m_ien = 0; m_raw = 0; m_fire = 0; m_fact = 0;
      m_div = 0; m_cnt = 0; m_stage = 0; m_pc[0] = 0; m_pc[1] = 0;
    end else begin
      kok  = (m_key == MAGIC);
      rd_n = rd_val(addr);
      feed = wr && kok && addr == 4'd6;
      drst = wr && kok && addr == 4'd1 && wd[31];
      for (int p = 0; p < 2; p++) begin
        if (m_fire && m_fact == 2 + p) m_pc[p] = WID[p == 0 ? a_cpu : a_sys];
        else if (m_pc[p] > 0) m_pc[p]--;
      end
      if (m_fire && m_fact == 1) m_raw = 1;
      else if (wr && addr == 4'd11 && wd[0]) m_raw = 0;
      peff = (a_pre == 0) ? 1 : a_pre;
      tick = a_en && (m_div + 1 >= peff);
      fire_n = 0;
      fact_n = a_act[m_stage];
      if (!a_en || feed) begin
        m_stage = 0; m_cnt = 0;
      end else if (tick) begin
        heff = (a_hold[m_stage] == 0) ? 1 : a_hold[m_stage];
        if (m_cnt + 1 >= heff) begin
          fire_n = 1; m_stage = (m_stage + 1) % 4; m_cnt = 0;
        end else m_cnt++;
      end
      if (!a_en || drst || feed || tick) m_div = 0; else m_div++;
      m_fire = fire_n; m_fact = fact_n;
      if (m_commit) begin
        a_en = s_en; a_pre = s_pre; a_cpu = s_cpu; a_sys = s_sys;
        for (int i = 0; i < 4; i++) begin a_act[i] = s_act[i]; a_hold[i] = s_hold[i]; end
      end
      m_commit = wr && kok && addr == 4'd0 && wd[30];
      if (wr && kok) begin
        case (addr)
          4'd0: begin
            s_en = wd[31]; s_cpu = int'(wd[10:8]); s_sys = int'(wd[13:11]);
            for (int i = 0; i < 4; i++) s_act[i] = int'(wd[2*i +: 2]);
          end
          4'd1: s_pre = longint'(wd[15:0]);
          4'd2, 4'd3, 4'd4, 4'd5: s_hold[addr-2] = longint'(wd);
          default: ;
        endcase
      end
      if (wr && addr == 4'd7) m_key = wd;
      if (wr && addr == 4'd8) m_ien = wd[0];
      m_rd = rd_n;
    end
  end

  task automatic fail_line(input string req, input string what, input longint act, input longint exp);
    n_fail++;
    $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", req, what, act, exp, $time);
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_tests++;
      if (irq !== (m_raw && m_ien)) fail_line("R7", "irq_o vs model", irq, m_raw && m_ien);
      if (cpu !== (m_pc[0] > 0))    fail_line("R8", "cpu_rst_o vs model", cpu, m_pc[0] > 0);
      if (sys !== (m_pc[1] > 0))    fail_line("R8", "sys_rst_o vs model", sys, m_pc[1] > 0);
      if (rdata !== m_rd)           fail_line("R2", "rdata_o vs model", rdata, m_rd);
    end
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_tests++;
    if (act != exp) fail_line(req, what, act, exp);
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
    addr = a; wd = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0; wd = '0;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [31:0] v);
    addr = a;
    @(negedge clk);
    v = rdata;
  endtask

  function automatic logic [31:0] ctrl(input bit en, input bit commit, input int a0, input int a1,
                                       input int a2, input int a3, input int cc, input int sc);
    logic [31:0] v = '0;
    v[31] = en; v[30] = commit; v[13:11] = 3'(sc); v[10:8] = 3'(cc);
    v[1:0] = 2'(a0); v[3:2] = 2'(a1); v[5:4] = 2'(a2); v[7:6] = 2'(a3);
    return v;
  endfunction

  task automatic finish_run();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      fail_line("R1", "watchdog expired, cycles", cyc, 100000);
      finish_run();
    end
  end

  initial begin
    logic [31:0] v;
    int cnt_c, cnt_s;
    bit seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1", "irq_o", irq, 0);
    chk("R1", "cpu_rst_o", cpu, 0);
    chk("R1", "sys_rst_o", sys, 0);
    rd_reg(4'd7, v); chk("R1", "key", v, MAGIC);
    rd_reg(4'd2, v); chk("R1", "hold0", v, 26000000);
    rd_reg(4'd3, v); chk("R1", "hold1", v, 134217727);
    rd_reg(4'd5, v); chk("R1", "hold3", v, 1048575);
    rd_reg(4'd1, v); chk("R1", "prescale", v, 1);
    rd_reg(4'd0, v); chk("R1", "ctrl", v, 32'h900);

    // R3 staged but not committed
    wr_reg(4'd2, 5); wr_reg(4'd3, 3); wr_reg(4'd4, 0); wr_reg(4'd5, 2);
    wr_reg(4'd8, 1);
    wr_reg(4'd0, ctrl(1, 0, 1, 0, 2, 3, 1, 1));
    repeat (20) @(negedge clk);
    chk("R3", "irq before commit", irq, 0);
    chk("R3", "cpu before commit", cpu, 0);

    // R4 first expiry timing after commit
    wr_reg(4'd0, ctrl(1, 1, 1, 0, 2, 3, 1, 1));
    repeat (6) @(negedge clk);
    chk("R4", "irq one cycle early", irq, 0);
    @(negedge clk);
    chk("R4", "irq at expiry", irq, 1);
    seen = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (cpu) seen = 1; end
    chk("R8", "cpu pulse seen", seen, 1);

    // R7 masking and clear, R10 disable
    wr_reg(4'd0, ctrl(0, 1, 1, 0, 2, 3, 1, 1));
    repeat (300) @(negedge clk);
    chk("R10", "cpu idle after disable", cpu, 0);
    chk("R10", "sys idle after disable", sys, 0);
    wr_reg(4'd8, 0);
    chk("R7", "irq masked", irq, 0);
    rd_reg(4'd9, v);  chk("R7", "raw still set", v, 1);
    rd_reg(4'd10, v); chk("R7", "masked status", v, 0);
    wr_reg(4'd11, 1);
    rd_reg(4'd9, v);  chk("R7", "raw cleared", v, 0);
    wr_reg(4'd8, 1);

    // R6 feeding holds off expiry
    wr_reg(4'd0, ctrl(1, 1, 1, 0, 2, 3, 1, 1));
    for (int i = 0; i < 20; i++) begin wr_reg(4'd6, 32'h0); @(negedge clk); end
    chk("R6", "irq while fed", irq, 0);
    wr_reg(4'd6, 32'hFFFF_FFFF);
    repeat (5) @(negedge clk);
    chk("R6", "irq one cycle early after feed", irq, 0);
    @(negedge clk);
    chk("R6", "irq after last feed", irq, 1);

    // R2 write lock
    wr_reg(4'd0, ctrl(0, 1, 1, 0, 2, 3, 1, 1));
    repeat (300) @(negedge clk);
    wr_reg(4'd11, 1);
    wr_reg(4'd7, 32'h0);
    wr_reg(4'd2, 99);
    wr_reg(4'd0, ctrl(1, 1, 3, 3, 3, 3, 0, 0));
    rd_reg(4'd2, v); chk("R2", "hold0 locked", v, 5);
    rd_reg(4'd0, v); chk("R2", "ctrl locked", v, ctrl(0, 0, 1, 0, 2, 3, 1, 1));
    repeat (20) @(negedge clk);
    chk("R2", "locked commit ignored", sys, 0);
    rd_reg(4'd7, v); chk("R2", "key readback", v, 0);
    wr_reg(4'd7, MAGIC);
    wr_reg(4'd2, 99);
    rd_reg(4'd2, v); chk("R2", "hold0 unlocked", v, 99);

    // R5 prescale 3, hold 2
    wr_reg(4'd1, 3); wr_reg(4'd2, 2);
    wr_reg(4'd0, ctrl(1, 1, 1, 0, 0, 0, 1, 1));
    repeat (7) @(negedge clk);
    chk("R5", "irq one cycle early", irq, 0);
    @(negedge clk);
    chk("R5", "irq at prescaled expiry", irq, 1);
    wr_reg(4'd0, ctrl(0, 1, 1, 0, 0, 0, 1, 1));
    wr_reg(4'd11, 1);
    wr_reg(4'd0, ctrl(1, 1, 1, 0, 0, 0, 1, 1));
    for (int i = 0; i < 20; i++) begin wr_reg(4'd1, 32'h8000_0003); @(negedge clk); end
    chk("R5", "divider restart holds off ticks", irq, 0);

    // R9 action none
    wr_reg(4'd0, ctrl(0, 1, 0, 0, 0, 0, 1, 1));
    wr_reg(4'd11, 1);
    wr_reg(4'd1, 1);
    wr_reg(4'd2, 1); wr_reg(4'd3, 1); wr_reg(4'd4, 1); wr_reg(4'd5, 1);
    wr_reg(4'd0, ctrl(1, 1, 0, 0, 0, 0, 1, 1));
    seen = 0;
    for (int i = 0; i < 60; i++) begin @(negedge clk); if (irq || cpu || sys) seen = 1; end
    chk("R9", "no output with action none", seen, 0);
    rd_reg(4'd9, v); chk("R9", "raw untouched", v, 0);

    // R8 pulse widths, codes 7 and 0
    wr_reg(4'd0, ctrl(0, 1, 0, 0, 0, 0, 1, 1));
    wr_reg(4'd4, 400); wr_reg(4'd5, 400);
    wr_reg(4'd0, ctrl(1, 1, 2, 3, 0, 0, 7, 0));
    cnt_c = 0; cnt_s = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (cpu) cnt_c++;
      if (sys) cnt_s++;
    end
    chk("R8", "cpu pulse width code 7", cnt_c, 256);
    chk("R8", "sys pulse width code 0", cnt_s, 8);
    wr_reg(4'd0, ctrl(0, 1, 0, 0, 0, 0, 1, 1));
    repeat (5) @(negedge clk);
    chk("R10", "no pulse after disable", cpu | sys, 0);

    finish_run();
  end
endmodule